// File: doc/BRIEF.md
# Floating-Point Register Bit Branch Resolver

This unit resolves conditional branches that test the least significant bit of a 64-bit floating-point register, for a 64-bit pipeline with a branch delay slot. On a valid strobe it captures the program counter, a 16-bit signed word offset, the register value and an operation select. One cycle later it presents the registered outcome: whether the branch is taken, the next program counter, and a flag telling the pipeline that the delay-slot instruction runs.

Two operations are supported. One branches when the tested bit is clear and the other branches when it is set. The delay-slot instruction runs in every case. A taken branch goes to the branch address plus the scaled offset plus 4. A branch that is not taken continues after the delay slot. Any other operation select code raises an illegal flag and does not take the branch.

Top module: `fpbit_branch`

## Requirements
- R1: The operation select is 2 bits wide. Code 2'b01 is branch-if-clear, and it is taken exactly when bit 0 of the register value is 0.
- R2: Code 2'b10 is branch-if-set, and it is taken exactly when bit 0 of the register value is 1.
- R3: For a taken branch, nextPc equals pc + (sign-extended offset << 2) + 4, computed modulo 2^64.
- R4: For a legal branch that is not taken, and for an illegal select, nextPc equals pc + 8.
- R5: For a legal select, slotExec is 1 whether or not the branch is taken.
- R6: Bits 63 to 1 of the register value have no effect on taken or nextPc.
- R7: outValid is 1 in the cycle after each cycle in which inValid is 1, and 0 otherwise. All outputs are registered.
- R8: Select codes 2'b00 and 2'b11 set illegal to 1 and hold taken and slotExec at 0. A legal select leaves illegal at 0.
- R9: After reset, outValid, taken, slotExec and illegal are 0 and nextPc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Branch request strobe |
| opSel | input | 2 | 01 branch-if-clear, 10 branch-if-set |
| pc | input | 64 | Address of the branch |
| offset | input | 16 | Signed word offset |
| fpVal | input | 64 | Floating-point register value |
| outValid | output | 1 | Result valid, one cycle after inValid |
| taken | output | 1 | Branch taken |
| nextPc | output | 64 | Next program counter |
| slotExec | output | 1 | Delay-slot instruction runs |
| illegal | output | 1 | Select code not recognised |

## Verification
The hardest cases to reach are the ones where address arithmetic wraps. This happens when a large negative offset is combined with a small pc, or when pc is near 2^64 and the +8 or +4 crosses zero. The vector table includes pc and offset values chosen to produce both wraps. It also includes register values whose upper bits are all ones or all zeros, and back-to-back strobes in consecutive cycles, which confirm that outValid does not stretch.

// File: rtl/fpbit_branch_pkg.sv
package fpbit_branch_pkg;
  localparam int PC_W  = 64;
  localparam int OFF_W = 16;
  typedef enum logic [1:0] {
    OP_BAD0 = 2'b00,
    OP_CLR  = 2'b01,
    OP_SET  = 2'b10,
    OP_BAD3 = 2'b11
  } brOp_e;
  typedef struct packed {
    logic load;
    logic isTaken;
    logic isLegal;
  } ctlStrobe_t;
endpackage

// File: rtl/fpbit_branch_ctl.sv
module fpbit_branch_ctl
  import fpbit_branch_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic       condBit,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe.load    = inValid;
    strobe.isLegal = 1'b0;
    strobe.isTaken = 1'b0;
    unique case (opSel)
      OP_CLR: begin strobe.isLegal = 1'b1; strobe.isTaken = ~condBit; end
      OP_SET: begin strobe.isLegal = 1'b1; strobe.isTaken = condBit; end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpbit_branch_dp.sv
module fpbit_branch_dp
  import fpbit_branch_pkg::*;
#(
  parameter int PcW  = PC_W,
  parameter int OffW = OFF_W,
  parameter int InstrBytes = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [PcW-1:0]  pc,
  input  logic [OffW-1:0] offset,
  output logic            outValid,
  output logic            taken,
  output logic [PcW-1:0]  nextPc,
  output logic            slotExec,
  output logic            illegal
);
  localparam logic [PcW-1:0] STEP = PcW'(InstrBytes);
  localparam logic [PcW-1:0] SKIP = PcW'(2 * InstrBytes);

  logic [PcW-1:0] offExt;
  logic [PcW-1:0] takenPc;
  logic [PcW-1:0] fallPc;

  assign offExt  = {{(PcW-OffW){offset[OffW-1]}}, offset} << 2;
  assign takenPc = pc + offExt + STEP;
  assign fallPc  = pc + SKIP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
      slotExec <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        taken    <= strobe.isTaken;
        nextPc   <= strobe.isTaken ? takenPc : fallPc;
        slotExec <= strobe.isLegal;
        illegal  <= ~strobe.isLegal;
      end
    end
  end

  // R7: the result strobe follows each request by exactly one cycle
  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid);
  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !outValid);
  // R8: an illegal result never reports taken or runs the slot
  p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!taken && !slotExec));
  // R5: a legal result always runs the delay slot
  p_slot_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (slotExec == !illegal));
  // R4: the fall-through address comes from the captured pc
  p_fall_pc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.isTaken) |=> (nextPc == $past(pc) + SKIP));
endmodule

// File: rtl/fpbit_branch.sv
module fpbit_branch
  import fpbit_branch_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opSel,
  input  logic [63:0] pc,
  input  logic [15:0] offset,
  input  logic [63:0] fpVal,
  output logic        outValid,
  output logic        taken,
  output logic [63:0] nextPc,
  output logic        slotExec,
  output logic        illegal
);
  ctlStrobe_t strobe;

  fpbit_branch_ctl uCtl (
    .inValid(inValid),
    .opSel(opSel),
    .condBit(fpVal[0]),
    .strobe(strobe)
  );

  fpbit_branch_dp #(.PcW(64), .OffW(16), .InstrBytes(4)) uDp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .pc(pc),
    .offset(offset),
    .outValid(outValid),
    .taken(taken),
    .nextPc(nextPc),
    .slotExec(slotExec),
    .illegal(illegal)
  );

  // R1 and R2: a captured legal clear-test is taken iff bit 0 was clear
  p_clr_cond_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b01) |=> (taken == !$past(fpVal[0])));
  p_set_cond_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'b10) |=> (taken == $past(fpVal[0])));
endmodule

// File: tb/sim_fpbit_branch.sv
`timescale 1ns/1ps
module sim_fpbit_branch;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] opSel = '0;
  logic [63:0] pc = '0;
  logic [15:0] offset = '0;
  logic [63:0] fpVal = '0;
  logic outValid, taken, slotExec, illegal;
  logic [63:0] nextPc;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  fpbit_branch u0 (.*);

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] p;
    logic [15:0] off;
    logic [63:0] v;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 64'h1000, 16'h0010, 64'h0},
    '{2'b01, 64'h1000, 16'h0010, 64'h1},
    '{2'b10, 64'h2000, 16'hfff0, 64'h1},
    '{2'b10, 64'h2000, 16'hfff0, 64'h0},
    '{2'b01, 64'hffff_ffff_ffff_fffc, 16'h0000, 64'h1},
    '{2'b10, 64'h0000_0000_0000_0008, 16'h8000, 64'hffff_ffff_ffff_ffff},
    '{2'b01, 64'h4000, 16'h7fff, 64'hffff_ffff_ffff_fffe},
    '{2'b10, 64'h4000, 16'h7fff, 64'hffff_ffff_ffff_fffe},
    '{2'b00, 64'h3000, 16'h0004, 64'h0},
    '{2'b11, 64'hffff_ffff_ffff_fff8, 16'h0004, 64'h1}
  };

  function automatic logic [63:0] expPc(vec_t x, logic tk);
    logic [63:0] o;
    o = {{48{x.off[15]}}, x.off};
    return tk ? x.p + (o << 2) + 64'd4 : x.p + 64'd8;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(vec_t x);
    @(negedge clk);
    inValid = 1'b1; opSel = x.op; pc = x.p; offset = x.off; fpVal = x.v;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkVec(vec_t x, string tag);
    logic lg, tk;
    lg = (x.op == 2'b01) || (x.op == 2'b10);
    tk = (x.op == 2'b01) ? !x.v[0] : (x.op == 2'b10) ? x.v[0] : 1'b0;
    chk({tag, " R7 outValid"}, 64'(outValid), 64'd1);
    chk({tag, " R1/R2 taken"}, 64'(taken), 64'(tk));
    chk({tag, " R3/R4 nextPc"}, nextPc, expPc(x, tk));
    chk({tag, " R5 slotExec"}, 64'(slotExec), 64'(lg));
    chk({tag, " R8 illegal"}, 64'(illegal), 64'(!lg));
  endtask

  initial begin
    #40000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 outValid", 64'(outValid), 0);
    chk("R9 taken", 64'(taken), 0);
    chk("R9 nextPc", nextPc, 0);
    chk("R9 slotExec", 64'(slotExec), 0);
    chk("R9 illegal", 64'(illegal), 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      checkVec(VECS[i], "vec");
      @(negedge clk);
      chk("R7 valid drops", 64'(outValid), 0);
    end

    // R6: upper bits ignored, same bit 0 gives same result
    begin
      vec_t a, b;
      a = '{2'b01, 64'h500, 16'h0003, 64'h0};
      b = '{2'b01, 64'h500, 16'h0003, 64'haaaa_5555_ffff_0000};
      drive(a); checkVec(a, "R6 a");
      drive(b); checkVec(b, "R6 b");
      chk("R6 taken upper ones", 64'(taken), 64'd1);
    end

    // R7 back-to-back strobes
    begin
      vec_t a, b;
      a = '{2'b10, 64'h100, 16'h0001, 64'h1};
      b = '{2'b10, 64'h200, 16'h0001, 64'h0};
      @(negedge clk);
      inValid = 1'b1; opSel = a.op; pc = a.p; offset = a.off; fpVal = a.v;
      @(negedge clk);
      checkVec(a, "R7 b2b first");
      opSel = b.op; pc = b.p; offset = b.off; fpVal = b.v;
      @(negedge clk);
      inValid = 1'b0;
      checkVec(b, "R7 b2b second");
      @(negedge clk);
      chk("R7 after b2b", 64'(outValid), 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule